// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status word of a small eight-bit processor core. It keeps the global interrupt enable, a one-bit transfer store used by bit-copy instructions, and six arithmetic flags: half carry, sign, overflow, negative, zero and carry. The ALU, the instruction decoder and the register file sit outside the block. They reach it through plain strobes and data ports. Each ALU update carries a per-flag write mask. Software can read the whole word, and it can write the whole word in one cycle.

The sign flag is never stored on its own terms. It is always the exclusive OR of the negative and overflow flags, so it stays consistent whatever writes the word. The interrupt enable is a two-state machine with the states MASKED (enable bit 0) and ARMED (enable bit 1). It has four named transitions:

- TAKE (ARMED to MASKED) happens on interrupt entry.
- RETURN (MASKED to ARMED) happens on the return-from-interrupt strobe.
- SOFT_ARM (MASKED to ARMED) happens on a software write with bit 7 set.
- SOFT_MASK (ARMED to MASKED) happens on a software write with bit 7 clear.

Interrupt entry and return touch only the enable bit. The rest of the word is neither saved nor restored.

Top module: `cpu_status_reg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `status_q` reads 8'h00.
- R2: The word layout, from bit 7 down to bit 0, is I, T, H, S, V, N, Z, C. When `alu_upd` is high and `sw_wr` is low, each arithmetic flag whose bit in `alu_mask` is 1 takes the value of the same bit of `alu_flags` on the next cycle. The bit order of the mask and the flags is [5]=H, [4]=S, [3]=V, [2]=N, [1]=Z, [0]=C. A flag whose mask bit is 0 keeps its value.
- R3: `status_q[4]` always equals `status_q[3] ^ status_q[2]`. The S position of `alu_flags` is ignored, and so is the S position of `sw_data`.
- R4: When `sw_wr` is high, bits 6..0 take `sw_data` on the next cycle, with S recomputed from the written N and V. The write takes priority over an ALU update and over a bit-store in the same cycle.
- R5: When `irq_enter` is high, I is 0 on the next cycle. This wins over `irq_return` and over a software write of I, and it leaves T and the arithmetic flags as they would be without it.
- R6: When `irq_return` is high and `irq_enter` is low, I is 1 on the next cycle. This wins over a software write of I. No other bit is affected.
- R7: When `tcopy_store` is high and `sw_wr` is low, T takes `tcopy_src[tcopy_idx]` on the next cycle. No other bit changes.
- R8: `tcopy_result` is combinational. While `tcopy_load` is high it equals `tcopy_src` with bit `tcopy_idx` replaced by the current T. While `tcopy_load` is low it equals `tcopy_src` unchanged.
- R9: An ALU update never changes I or T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_mask | input | 6 | Per-flag write mask (H,S,V,N,Z,C from bit 5 down) |
| alu_flags | input | 6 | New flag values, same order as the mask |
| sw_wr | input | 1 | Software write of the whole word |
| sw_data | input | 8 | Software write data |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| tcopy_store | input | 1 | Bit-store: operand bit into T |
| tcopy_load | input | 1 | Bit-load: T into operand bit |
| tcopy_idx | input | 3 | Bit index for the store and the load |
| tcopy_src | input | 8 | Register operand |
| tcopy_result | output | 8 | Operand after the bit-load |
| status_q | output | 8 | Current status word |

## Verification
The hardest situation to reach from the ports is a collision on the enable bit, where interrupt entry, interrupt return and a software write with either value of bit 7 arrive in the same cycle. The stimulus drives all sixteen combinations of these strobes and the written bit. It starts each combination once from the MASKED state and once from the ARMED state, and it compares the whole word so that the other bits are shown to be undisturbed. Full sweeps of the mask against the flag values, and of the bit index against every operand, cover the flag and bit-copy paths.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
    localparam int STAT_W = 8;
    localparam int FLAG_W = 6;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    // positions in the status word
    localparam int POS_I = 7;
    localparam int POS_T = 6;

    // positions inside the arithmetic flag field (also word bits 5..0)
    localparam int FL_H = 5;
    localparam int FL_S = 4;
    localparam int FL_V = 3;
    localparam int FL_N = 2;
    localparam int FL_Z = 1;
    localparam int FL_C = 0;

    typedef enum logic {
        IE_MASKED = 1'b0,
        IE_ARMED  = 1'b1
    } ie_state_t;
endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic [FLAG_W-1:0] alu_mask,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              sw_wr,
    input  logic [FLAG_W-1:0] sw_flags,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] flags_d;

    // next value: software write, then masked ALU update, then hold
    always_comb begin
        for (int i = 0; i < FLAG_W; i++) begin
            if (sw_wr)
                flags_d[i] = sw_flags[i];
            else if (alu_upd && alu_mask[i])
                flags_d[i] = alu_flags[i];
            else
                flags_d[i] = flags_q[i];
        end
        // sign is derived, never taken from an input
        flags_d[FL_S] = flags_d[FL_V] ^ flags_d[FL_N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end
endmodule

// File: rtl/status_tbit.sv
module status_tbit
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_t,
    input  logic              tcopy_store,
    input  logic              tcopy_load,
    input  logic [IDX_W-1:0]  tcopy_idx,
    input  logic [DATA_W-1:0] tcopy_src,
    output logic [DATA_W-1:0] tcopy_result,
    output logic              t_q
);
    logic t_d;

    always_comb begin
        if (sw_wr)
            t_d = sw_t;
        else if (tcopy_store)
            t_d = tcopy_src[tcopy_idx];
        else
            t_d = t_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= 1'b0;
        else
            t_q <= t_d;
    end

    // bit-load: replace the selected operand bit by T
    always_comb begin
        tcopy_result = tcopy_src;
        for (int b = 0; b < DATA_W; b++) begin
            if (tcopy_load && (tcopy_idx == IDX_W'(b)))
                tcopy_result[b] = t_q;
        end
    end
endmodule

// File: rtl/status_ie_ctrl.sv
module status_ie_ctrl
    import cpu_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_enter,
    input  logic irq_return,
    input  logic sw_wr,
    input  logic sw_i,
    output logic ie_q
);
    ie_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IE_MASKED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IE_MASKED: begin
                // RETURN or SOFT_ARM, blocked by a same-cycle entry
                if (!irq_enter && (irq_return || (sw_wr && sw_i)))
                    state_d = IE_ARMED;
            end
            IE_ARMED: begin
                // TAKE, or SOFT_MASK when no return is pending
                if (irq_enter || (!irq_return && sw_wr && !sw_i))
                    state_d = IE_MASKED;
            end
            default: state_d = IE_MASKED;
        endcase
    end

    always_comb begin
        ie_q = (state_q == IE_ARMED);
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic [FLAG_W-1:0] alu_mask,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_data,
    input  logic              irq_enter,
    input  logic              irq_return,
    input  logic              tcopy_store,
    input  logic              tcopy_load,
    input  logic [IDX_W-1:0]  tcopy_idx,
    input  logic [DATA_W-1:0] tcopy_src,
    output logic [DATA_W-1:0] tcopy_result,
    output logic [STAT_W-1:0] status_q
);
    logic [FLAG_W-1:0] flags_q;
    logic              t_q;
    logic              ie_q;

    status_arith_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_upd   (alu_upd),
        .alu_mask  (alu_mask),
        .alu_flags (alu_flags),
        .sw_wr     (sw_wr),
        .sw_flags  (sw_data[FLAG_W-1:0]),
        .flags_q   (flags_q)
    );

    status_tbit u_tbit (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr        (sw_wr),
        .sw_t         (sw_data[POS_T]),
        .tcopy_store  (tcopy_store),
        .tcopy_load   (tcopy_load),
        .tcopy_idx    (tcopy_idx),
        .tcopy_src    (tcopy_src),
        .tcopy_result (tcopy_result),
        .t_q          (t_q)
    );

    status_ie_ctrl u_ie (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .sw_wr      (sw_wr),
        .sw_i       (sw_data[POS_I]),
        .ie_q       (ie_q)
    );

    assign status_q = {ie_q, t_q, flags_q};
endmodule

// File: rtl/cpu_status_chk.sv
module cpu_status_chk
    import cpu_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              alu_upd,
    input logic              sw_wr,
    input logic [STAT_W-1:0] sw_data,
    input logic              irq_enter,
    input logic              irq_return,
    input logic              tcopy_store,
    input logic [IDX_W-1:0]  tcopy_idx,
    input logic [DATA_W-1:0] tcopy_src,
    input logic [STAT_W-1:0] status_q
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> status_q == '0);

    p_sign_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[FL_S] == (status_q[FL_V] ^ status_q[FL_N]));

    p_sw_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (status_q[POS_T] == $past(sw_data[POS_T])) &&
                  (status_q[FL_H] == $past(sw_data[FL_H])) &&
                  (status_q[FL_V] == $past(sw_data[FL_V])) &&
                  (status_q[FL_N] == $past(sw_data[FL_N])) &&
                  (status_q[FL_Z] == $past(sw_data[FL_Z])) &&
                  (status_q[FL_C] == $past(sw_data[FL_C])));

    p_entry_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !status_q[POS_I]);

    p_return_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter) |=> status_q[POS_I]);

    p_store_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tcopy_store && !sw_wr) |=> status_q[POS_T] == $past(tcopy_src[tcopy_idx]));

    p_alu_spares_it_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && !sw_wr && !tcopy_store && !irq_enter && !irq_return)
            |=> $stable(status_q[POS_I:POS_T]));
endmodule

bind cpu_status_reg cpu_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_upd     (alu_upd),
    .sw_wr       (sw_wr),
    .sw_data     (sw_data),
    .irq_enter   (irq_enter),
    .irq_return  (irq_return),
    .tcopy_store (tcopy_store),
    .tcopy_idx   (tcopy_idx),
    .tcopy_src   (tcopy_src),
    .status_q    (status_q)
);

// File: tb/test_cpu_status_reg.sv
`timescale 1ns/1ps
module test_cpu_status_reg;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alu_upd;
    logic [5:0] alu_mask;
    logic [5:0] alu_flags;
    logic       sw_wr;
    logic [7:0] sw_data;
    logic       irq_enter;
    logic       irq_return;
    logic       tcopy_store;
    logic       tcopy_load;
    logic [2:0] tcopy_idx;
    logic [7:0] tcopy_src;
    logic [7:0] tcopy_result;
    logic [7:0] status_q;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [7:0] exp_st;

    always #(CLK_NS/2) clk = ~clk;

    cpu_status_reg i_cpu_status_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .alu_upd      (alu_upd),
        .alu_mask     (alu_mask),
        .alu_flags    (alu_flags),
        .sw_wr        (sw_wr),
        .sw_data      (sw_data),
        .irq_enter    (irq_enter),
        .irq_return   (irq_return),
        .tcopy_store  (tcopy_store),
        .tcopy_load   (tcopy_load),
        .tcopy_idx    (tcopy_idx),
        .tcopy_src    (tcopy_src),
        .tcopy_result (tcopy_result),
        .status_q     (status_q)
    );

    // expected next word from the requirements
    function automatic logic [7:0] model_next(input logic [7:0] cur);
        logic [7:0] nx;
        nx = cur;
        for (int b = 0; b < 6; b++) begin
            if (b != 4) begin
                if (sw_wr)                      nx[b] = sw_data[b];
                else if (alu_upd && alu_mask[b]) nx[b] = alu_flags[b];
            end
        end
        nx[4] = nx[3] ^ nx[2];
        if (sw_wr)            nx[6] = sw_data[6];
        else if (tcopy_store) nx[6] = tcopy_src[tcopy_idx];
        if (irq_enter)        nx[7] = 1'b0;
        else if (irq_return)  nx[7] = 1'b1;
        else if (sw_wr)       nx[7] = sw_data[7];
        return nx;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alu_upd = 0; alu_mask = 0; alu_flags = 0; sw_wr = 0; sw_data = 0;
        irq_enter = 0; irq_return = 0; tcopy_store = 0; tcopy_load = 0;
        tcopy_idx = 0; tcopy_src = 0;
    endtask

    task automatic tick(input string tag);
        exp_st = model_next(exp_st);
        @(posedge clk);
        #1;
        chk(tag, status_q, exp_st);
        chk("R3 sign", {7'b0, status_q[4]}, {7'b0, status_q[3] ^ status_q[2]});
        idle();
    endtask

    task automatic preset(input logic [7:0] v);
        idle();
        sw_wr = 1; sw_data = v;
        tick("R4 preset");
    endtask

    initial begin
        idle();
        rst_n  = 1'b0;
        exp_st = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", status_q, 8'h00);
        rst_n = 1'b1;
        tick("R1 after release");

        // R4: every software write value
        for (int v = 0; v < 256; v++) begin
            sw_wr = 1; sw_data = 8'(v);
            tick("R4 write");
        end

        // R4 priority over ALU and bit-store
        for (int v = 0; v < 16; v++) begin
            sw_wr = 1; sw_data = 8'(v * 17);
            alu_upd = 1; alu_mask = 6'h3F; alu_flags = ~6'(v * 17);
            tcopy_store = 1; tcopy_src = ~8'(v * 17); tcopy_idx = 3'd6;
            tick("R4 priority");
        end

        // R2/R3/R9: mask x flag value sweep
        for (int m = 0; m < 64; m++) begin
            preset(8'((m * 37) ^ 8'hC0));
            for (int f = 0; f < 64; f++) begin
                alu_upd = 1; alu_mask = 6'(m); alu_flags = 6'(f);
                tick("R2 R9 alu update");
            end
        end

        // R7: bit-store of every index and operand
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 256; s++) begin
                tcopy_store = 1; tcopy_idx = 3'(i); tcopy_src = 8'(s);
                tick("R7 bit store");
            end
        end

        // R8: bit-load combinational result, T at 0 and at 1
        for (int t = 0; t < 2; t++) begin
            preset(t ? 8'h40 : 8'hBF);
            for (int i = 0; i < 8; i++) begin
                for (int s = 0; s < 256; s++) begin
                    logic [7:0] want;
                    want = 8'(s);
                    want[i] = t[0];
                    tcopy_load = 1; tcopy_idx = 3'(i); tcopy_src = 8'(s);
                    #1;
                    chk("R8 bit load", tcopy_result, want);
                    tcopy_load = 0;
                    #1;
                    chk("R8 pass through", tcopy_result, 8'(s));
                end
            end
            idle();
        end

        // R5/R6: entry, return and software write collisions from both I states
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 16; c++) begin
                preset(p ? 8'hA5 : 8'h5A);
                irq_enter  = c[0];
                irq_return = c[1];
                sw_wr      = c[2];
                sw_data    = {c[3], 7'h33};
                tick(c[0] ? "R5 entry collision" : "R6 return collision");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule